// File: doc/BRIEF.md
# Multi-Write-Port Synchronous RAM with Live Value Table

This block is a synchronous memory that accepts several writes and serves several reads in every clock cycle. It is built only from simple memories that have one write and one read port each. Every write port keeps its own copy of the memory, and that copy is repeated once for each read port. A small table of flip-flops, the live value table, records for each address which write port stored the newest value there. Each read port looks up that table and steers its output multiplexer to the copy that holds the newest value.

Data width, depth and the number of write and read ports are parameters. The defaults are 8-bit words, 32 entries, two write ports and two read ports. Reads have one cycle of latency. Data in the memory copies is undefined until written. Reset clears only the table.

Top module: `mwport_ram`

## Requirements
- R1: A value written through any write port is returned by any read port that reads that address later.
- R2: A read address presented in cycle t gives its data on the read port after the next rising clock edge, and the data stays there until the following edge.
- R3: Writes from different ports to different addresses in the same cycle all take effect. For example, port 0 writes address 0x12 and port 1 writes address 0x15 together, and both values read back afterwards.
- R4: When several write ports write the same address in the same cycle, the highest-numbered enabled port sets the stored value.
- R5: A read of an address that is being written in the same cycle returns the value held before that write.
- R6: All read ports work independently in the same cycle, on the same address or on different ones.
- R7: A write port whose enable bit is 0 changes nothing, whatever its address and data inputs carry.
- R8: An active-low reset points every table entry back at write port 0. An address last written by a higher port then reads port 0's most recent value for that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset of the live value table |
| wr_en | input | NW | Write enable, bit k for write port k |
| wr_addr | input | NW*AW | Write addresses, port k in bits [k*AW +: AW] |
| wr_data | input | NW*DW | Write data, port k in bits [k*DW +: DW] |
| rd_addr | input | NR*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NR*DW | Registered read data, port r in bits [r*DW +: DW] |

## Verification
First, every address is written once from each write port on its own and then read on every read port. This separates a correct copy selection from a stuck or swapped multiplexer. A sweep in which both write ports hit the same address shows whether the priority is set correctly. A sweep that reads and writes the same address in one cycle separates old-data behaviour from write-through. Directed steps cover disabled writers that carry live data, the two-address example, and a reset that happens after port 1 owns an address. Finally, a long run of random concurrent traffic on all ports is compared against a model in which every port is truly independent.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  // width of an index that can name n items (at least one bit)
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mwp_bank.sv
// One-write, one-read synchronous memory copy; read returns pre-write data.
module mwp_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mwp_live_table.sv
// Flip-flop table of newest writer per address, with registered lookups.
module mwp_live_table #(
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int IW    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*IW-1:0] sel_q
);
  logic [IW-1:0] owner_q [DEPTH];
  logic [IW-1:0] owner_d [DEPTH];
  logic [NR*IW-1:0] sel_d;

  // next state: ascending port order so the highest port wins a clash
  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      owner_d[a] = owner_q[a];
    end
    for (int k = 0; k < NW; k++) begin
      if (wr_en[k]) begin
        owner_d[wr_addr[k*AW +: AW]] = IW'(k);
      end
    end
  end

  // lookup uses the table before this cycle's writes (old data)
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      sel_d[r*IW +: IW] = owner_q[rd_addr[r*AW +: AW]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) begin
        owner_q[a] <= '0;
      end
      sel_q <= '0;
    end else begin
      for (int a = 0; a < DEPTH; a++) begin
        owner_q[a] <= owner_d[a];
      end
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/mwp_rd_select.sv
// Output multiplexer of one read port across the write ports' copies.
module mwp_rd_select #(
  parameter int NW = 2,
  parameter int DW = 8,
  parameter int IW = 1
) (
  input  logic [IW-1:0]    sel,
  input  logic [NW*DW-1:0] copies,
  output logic [DW-1:0]    dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < NW; k++) begin
      if (sel == IW'(k)) begin
        dout = copies[k*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/mwport_ram.sv
module mwport_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int NW    = 2,
  parameter int NR    = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IW   = mwp_pkg::idx_bits(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data
);
  logic [NR*IW-1:0] sel_q;
  logic [NW*DW-1:0] copy_q [NR];

  mwp_live_table #(
    .NW(NW), .NR(NR), .DEPTH(DEPTH), .AW(AW), .IW(IW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .sel_q   (sel_q)
  );

  for (genvar r = 0; r < NR; r++) begin : g_rd
    for (genvar w = 0; w < NW; w++) begin : g_wr
      mwp_bank #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk   (clk),
        .we    (wr_en[w]),
        .waddr (wr_addr[w*AW +: AW]),
        .wdata (wr_data[w*DW +: DW]),
        .raddr (rd_addr[r*AW +: AW]),
        .rdata (copy_q[r][w*DW +: DW])
      );
    end
    mwp_rd_select #(.NW(NW), .DW(DW), .IW(IW)) u_sel (
      .sel    (sel_q[r*IW +: IW]),
      .copies (copy_q[r]),
      .dout   (rd_data[r*DW +: DW])
    );
  end
endmodule

// File: rtl/mwp_ram_props.sv
module mwp_ram_props #(
  parameter int DW = 8,
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int AW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NW-1:0]    wr_en,
  input logic [NW*AW-1:0] wr_addr,
  input logic [NW*DW-1:0] wr_data,
  input logic [NR*AW-1:0] rd_addr,
  input logic [NR*DW-1:0] rd_data
);
  logic p0_sole;
  always_comb begin
    p0_sole = wr_en[0];
    for (int k = 1; k < NW; k++) begin
      if (wr_en[k] && (wr_addr[k*AW +: AW] == wr_addr[AW-1:0])) p0_sole = 1'b0;
    end
  end

  // R1
  sole_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p0_sole) && rd_addr[AW-1:0] == $past(wr_addr[AW-1:0]))
    |=> rd_data[DW-1:0] == $past(wr_data[DW-1:0], 2));

  // R4
  conflict_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en[0] && wr_en[NW-1] &&
           wr_addr[AW-1:0] == wr_addr[(NW-1)*AW +: AW]) &&
     rd_addr[AW-1:0] == $past(wr_addr[AW-1:0]))
    |=> rd_data[DW-1:0] == $past(wr_data[(NW-1)*DW +: DW], 2));

  // R5
  hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(|wr_en) && rd_addr[AW-1:0] == $past(rd_addr[AW-1:0]))
    |=> $stable(rd_data[DW-1:0]));

  // R6
  last_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en[NW-1]) &&
     rd_addr[(NR-1)*AW +: AW] == $past(wr_addr[(NW-1)*AW +: AW]))
    |=> rd_data[(NR-1)*DW +: DW] == $past(wr_data[(NW-1)*DW +: DW], 2));
endmodule

bind mwport_ram mwp_ram_props #(.DW(DW), .NW(NW), .NR(NR), .AW(AW)) u_props (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/mwport_ram_test.sv
module mwport_ram_test;
  localparam int DW = 8, DEPTH = 32, NW = 2, NR = 2, AW = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NW-1:0]    wr_en;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  bit            ref_ok  [DEPTH];

  always #10 clk = ~clk;

  mwport_ram #(.DW(DW), .DEPTH(DEPTH), .NW(NW), .NR(NR)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [DW-1:0] pat(input int k, input int a, input int s);
    return DW'(k * 64 + a * 3 + s * 17 + 7);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_w(input int k, input int a, input logic [DW-1:0] d);
    wr_en[k] = 1'b1;
    wr_addr[k*AW +: AW] = AW'(a);
    wr_data[k*DW +: DW] = d;
  endtask

  task automatic set_r(input int r, input int a);
    rd_addr[r*AW +: AW] = AW'(a);
  endtask

  // one clock: expected read data from the model before this cycle's writes
  task automatic cycle(input string tag);
    logic [DW-1:0] e [NR];
    bit v [NR];
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      e[r] = ref_mem[rd_addr[r*AW +: AW]];
      v[r] = ref_ok[rd_addr[r*AW +: AW]];
    end
    for (int k = 0; k < NW; k++) begin
      if (wr_en[k]) begin
        ref_mem[wr_addr[k*AW +: AW]] = wr_data[k*DW +: DW];
        ref_ok[wr_addr[k*AW +: AW]]  = 1'b1;
      end
    end
    #1;
    for (int r = 0; r < NR; r++) begin
      if (v[r]) chk(tag, rd_data[r*DW +: DW], e[r]);
    end
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) begin ref_ok[a] = 0; ref_mem[a] = '0; end
    do_reset();

    // R8: port 1 owns address 9, reset returns ownership to port 0
    set_w(0, 9, 8'h11); cycle("R1");
    set_w(1, 9, 8'h22); cycle("R1");
    set_r(0, 9); set_r(1, 9); cycle("R1");
    do_reset();
    ref_mem[9] = 8'h11;
    set_r(0, 9); set_r(1, 9); cycle("R8");

    // R1 / R2: each write port alone over every address, read on every port
    for (int k = 0; k < NW; k++) begin
      for (int a = 0; a < DEPTH; a++) begin
        set_w(k, a, pat(k, a, 0)); cycle("R1");
        set_r(0, a); set_r(1, a); cycle("R2");
      end
    end

    // R4: both writers hit the same address, port NW-1 must win
    for (int a = 0; a < DEPTH; a++) begin
      set_w(0, a, pat(0, a, 1)); set_w(1, a, pat(1, a, 1)); cycle("R4");
      set_r(0, a); set_r(1, a); cycle("R4");
    end

    // R3: two addresses written together
    set_w(0, 'h12, 8'hA5); set_w(1, 'h15, 8'h5A); cycle("R3");
    set_r(0, 'h15); set_r(1, 'h12); cycle("R3");
    chk("R3", rd_data[DW-1:0], 8'h5A);
    chk("R3", rd_data[DW +: DW], 8'hA5);

    // R5: read and write the same address in one cycle returns old value
    for (int a = 0; a < DEPTH; a++) begin
      set_r(0, a); set_r(1, a);
      set_w(a % NW, a, pat(a % NW, a, 2)); cycle("R5");
      cycle("R2");
    end

    // R7: disabled writers carry live address and data, nothing changes
    for (int a = 0; a < DEPTH; a++) begin
      wr_en = '0;
      wr_addr = {AW'(a), AW'(DEPTH - 1 - a)};
      wr_data = {8'hEE, 8'hDD};
      set_r(0, a); set_r(1, DEPTH - 1 - a); cycle("R7");
    end
    for (int a = 0; a < DEPTH; a++) begin
      set_r(0, a); set_r(1, a); cycle("R7");
    end

    // R6: random concurrent traffic on all ports
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < NW; k++) begin
        wr_en[k] = 1'($urandom_range(0, 1));
        wr_addr[k*AW +: AW] = AW'($urandom_range(0, DEPTH - 1));
        wr_data[k*DW +: DW] = DW'($urandom);
      end
      for (int r = 0; r < NR; r++) set_r(r, $urandom_range(0, DEPTH - 1));
      cycle("R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule